// File: doc/BRIEF.md
# Spread-Spectrum Feedback Divider Modulator

This block sits beside a fractional-N synthesizer and rewrites its feedback divider every reference cycle. The divider is held as one fixed-point number: an integer word above a fractional word. A signed offset that rises and falls in a triangle is added to the nominal divider. Because the output frequency follows the divider, the synthesized clock sweeps slowly across a narrow band, and the energy of the clock and its harmonics is spread over that band. The loop itself and the delta-sigma stage that consumes the fraction are outside this block.

The sweep comes from a divide-by-four prescale of the reference clock. A rate accumulator turns each prescaled tick into triangle steps, so that one full triangle lasts exactly `4 × rateDiv` reference cycles. Each quarter of the triangle has `2^STEP_SHIFT` steps, and the offset magnitude is the running sum of the depth, shifted right, so that the peak lands exactly on the programmed depth. In centre mode the offset swings between minus and plus depth. In down mode the whole triangle is moved down by one depth, so the excursion below nominal is twice the depth and the excursion above nominal is nothing. Depth, rate and mode are sampled while spreading is off, and while it is on they are sampled only when the triangle crosses its midpoint.

Top module: `ssfb_modulator`

## Requirements
- R1: While `rstN` is low (asynchronous), and in the reset state, the outputs equal the nominal divider and `phase` is 0.
- R2: In centre mode, after n triangle steps the offset is sign·floor(|L|/S), where S = 2^STEP_SHIFT, p = n mod 4S, k = p mod S, and L is k·D in quarter 0, (S−k)·D in quarter 1, −k·D in quarter 2 and −(S−k)·D in quarter 3. Here D is the depth in fractional LSBs and the quarter is floor(p/S). The peak offset is therefore exactly ±D.
- R3: With `downEn` set, the offset is the R2 value minus D, so it ranges from −2D up to 0.
- R4: Counting e rising edges after `spreadEn` goes high, the number of steps taken is n(e) = floor(floor(e/4)·4S/rateDiv). The outputs sampled after edge e show the offset for n(e−1), so one full triangle lasts 4·rateDiv reference cycles.
- R5: A `rateDiv` value below 18 is treated as 18.
- R6: `{modInt, modFrac}` equals ({nomInt, nomFrac} + offset) modulo 2^(INT_W+FRAC_W). Carries and borrows cross from the fraction into the integer word.
- R7: `phase` reports the quarter of the triangle for the step count the current output reflects: 0 rising from the midpoint, 1 falling back to it, 2 falling below it, 3 rising back to it.
- R8: Changes to depth, down-spread mode or rate made while spreading is active take effect only once the step count reaches a multiple of 2S (the triangle midpoint).
- R9: One rising edge after `spreadEn` falls, the outputs equal the nominal divider with `phase` 0. When spreading resumes, the triangle restarts from its midpoint.
- R10: A change to the nominal divider appears at the outputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nomInt | input | INT_W | Nominal integer divider |
| nomFrac | input | FRAC_W | Nominal fractional divider |
| depth | input | DEPTH_W | Modulation depth in fractional LSBs |
| rateDiv | input | RATE_W | Modulation-rate divider of refClk/4 |
| downEn | input | 1 | 1 = down spread, 0 = centre spread |
| spreadEn | input | 1 | Enables modulation |
| modInt | output | INT_W | Modulated integer divider |
| modFrac | output | FRAC_W | Modulated fractional divider |
| phase | output | 2 | Triangle quarter indicator |

## Verification
The bench sweeps depths 0, 1, 3, 7, 100 and 255 against rate dividers 18, 19, 25 and 33 in both spread modes, and checks every cycle of a full triangle plus a few cycles beyond it. The small depths separate the floor rounding from any drift in the accumulated remainder. The odd dividers separate exact step timing from a plain per-tick step. Rate values 0 and 5 must reproduce the timing of 18. Nominal values near the ends of the fraction and of the whole range show carry and borrow into the integer word. Separate runs change depth and mode inside the first quarter, drop the enable in mid-sweep, pull reset while running, and move the nominal value between edges.

// File: rtl/ssfb_pkg.sv
package ssfb_pkg;

  // Strobes from the sequencing control to the offset datapath.
  typedef struct packed {
    logic clr;   // spreading off: collapse the triangle to its start
    logic step;  // advance the triangle by one step this cycle
    logic rise;  // direction of the current step (1 = level grows)
    logic load;  // configuration is being sampled this cycle
  } strobe_t;

endpackage

// File: rtl/ssfb_ctrl.sv
module ssfb_ctrl
  import ssfb_pkg::*;
#(
  parameter int DEPTH_W    = 8,
  parameter int RATE_W     = 10,
  parameter int STEP_SHIFT = 2
) (
  input  logic               refClk,
  input  logic               rstN,
  input  logic               spreadEn,
  input  logic               downEn,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [RATE_W-1:0]  rateDiv,
  output strobe_t            stb,
  output logic [DEPTH_W-1:0] depthQ,
  output logic               downQ,
  output logic [1:0]         quarter
);

  localparam int POS_W    = STEP_SHIFT + 2;
  localparam int STEPS    = 1 << STEP_SHIFT;
  localparam int TICK_INC = 4 * STEPS;   // steps per prescaled tick, scaled by rateDiv
  localparam int MIN_DIV  = 18;          // keeps the sweep below fref/70
  localparam int ACC_W    = RATE_W + 1;

  logic [1:0]        preCnt;
  logic [ACC_W-1:0]  rateAcc;
  logic [ACC_W-1:0]  accSum;
  logic [RATE_W-1:0] divQ;
  logic [RATE_W-1:0] divLegal;
  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  posNext;
  logic              tick;
  logic              hit;
  logic              midNext;

  always_comb begin
    divLegal = (rateDiv < RATE_W'(MIN_DIV)) ? RATE_W'(MIN_DIV) : rateDiv;
    tick     = (preCnt == 2'd3);
    accSum   = rateAcc + ACC_W'(TICK_INC);
    hit      = tick && (accSum >= {1'b0, divQ});
    posNext  = pos + 1'b1;
    midNext  = (posNext[STEP_SHIFT:0] == '0);
    quarter  = pos[POS_W-1 -: 2];

    stb.clr  = !spreadEn;
    stb.step = spreadEn && hit;
    stb.rise = (quarter == 2'd0) || (quarter == 2'd3);
    stb.load = !spreadEn || (hit && midNext);
  end

  // Prescaler, rate accumulator and triangle position.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      rateAcc <= '0;
      pos     <= '0;
    end else if (stb.clr) begin
      preCnt  <= '0;
      rateAcc <= '0;
      pos     <= '0;
    end else begin
      preCnt <= preCnt + 2'd1;
      if (tick) begin
        rateAcc <= hit ? (accSum - {1'b0, divQ}) : accSum;
      end
      if (hit) begin
        pos <= posNext;
      end
    end
  end

  // Configuration is only sampled at the triangle midpoint or while idle.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      depthQ <= '0;
      divQ   <= RATE_W'(MIN_DIV);
      downQ  <= 1'b0;
    end else if (stb.load) begin
      depthQ <= depth;
      divQ   <= divLegal;
      downQ  <= downEn;
    end
  end

  assert_restart_midpoint_R9: assert property (@(posedge refClk) disable iff (!rstN)
    !spreadEn |=> (pos == '0) && (preCnt == 2'd0));

  assert_cfg_at_midpoint_R8: assert property (@(posedge refClk) disable iff (!rstN)
    (depthQ != $past(depthQ) || downQ != $past(downQ)) |-> (pos[STEP_SHIFT:0] == '0));

  assert_step_spacing_R4: assert property (@(posedge refClk) disable iff (!rstN)
    stb.step |=> !stb.step);

  assert_phase_order_R7: assert property (@(posedge refClk) disable iff (!rstN)
    (pos != $past(pos)) |-> ((pos == $past(pos) + 1'b1) || (pos == '0)));

endmodule

// File: rtl/ssfb_datapath.sv
module ssfb_datapath
  import ssfb_pkg::*;
#(
  parameter int INT_W      = 8,
  parameter int FRAC_W     = 12,
  parameter int DEPTH_W    = 8,
  parameter int STEP_SHIFT = 2
) (
  input  logic               refClk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [DEPTH_W-1:0] depthQ,
  input  logic               downQ,
  input  logic [1:0]         quarterIn,
  input  logic [INT_W-1:0]   nomInt,
  input  logic [FRAC_W-1:0]  nomFrac,
  output logic [INT_W-1:0]   modInt,
  output logic [FRAC_W-1:0]  modFrac,
  output logic [1:0]         phase
);

  localparam int LVL_W = DEPTH_W + STEP_SHIFT + 2;
  localparam int OFF_W = DEPTH_W + 2;
  localparam int SUM_W = INT_W + FRAC_W;

  logic signed [LVL_W-1:0] level;
  logic        [LVL_W-1:0] levelAbs;
  logic        [LVL_W-1:0] depthLvl;
  logic        [LVL_W-1:0] levelCap;
  logic signed [OFF_W-1:0] magS;
  logic signed [OFF_W-1:0] centreOff;
  logic signed [OFF_W-1:0] depthOff;
  logic signed [OFF_W-1:0] offNext;
  logic signed [OFF_W-1:0] offsetReg;
  logic        [SUM_W-1:0] nominal;
  logic        [SUM_W-1:0] offExt;
  logic        [SUM_W-1:0] total;

  always_comb begin
    depthLvl  = {{(LVL_W-DEPTH_W){1'b0}}, depthQ};
    levelCap  = depthLvl << STEP_SHIFT;
    levelAbs  = level[LVL_W-1] ? unsigned'(-level) : unsigned'(level);
    // Dropping the low bits keeps the remainder inside the level accumulator.
    magS      = signed'(levelAbs[LVL_W-1:STEP_SHIFT]);
    centreOff = level[LVL_W-1] ? -magS : magS;
    depthOff  = signed'({2'b00, depthQ});
    offNext   = downQ ? (centreOff - depthOff) : centreOff;

    nominal   = {nomInt, nomFrac};
    offExt    = {{(SUM_W-OFF_W){offsetReg[OFF_W-1]}}, offsetReg};
    total     = nominal + offExt;
    modInt    = total[SUM_W-1:FRAC_W];
    modFrac   = total[FRAC_W-1:0];
  end

  // Accumulated triangle level, S times the offset magnitude.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      level <= '0;
    end else if (stb.clr) begin
      level <= '0;
    end else if (stb.step) begin
      level <= stb.rise ? (level + signed'(depthLvl)) : (level - signed'(depthLvl));
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      offsetReg <= '0;
      phase     <= 2'd0;
    end else if (stb.clr) begin
      offsetReg <= '0;
      phase     <= 2'd0;
    end else begin
      offsetReg <= offNext;
      phase     <= quarterIn;
    end
  end

  assert_level_bound_R2: assert property (@(posedge refClk) disable iff (!rstN)
    levelAbs <= levelCap);

  assert_centre_range_R2: assert property (@(posedge refClk) disable iff (!rstN)
    !$past(downQ) |-> ((offsetReg <= $past(depthOff)) && (offsetReg >= -$past(depthOff))));

  assert_down_range_R3: assert property (@(posedge refClk) disable iff (!rstN)
    $past(downQ) |-> ((offsetReg <= 0) &&
                      (offsetReg + $past(depthOff) + $past(depthOff) >= 0)));

endmodule

// File: rtl/ssfb_modulator.sv
module ssfb_modulator
  import ssfb_pkg::*;
#(
  parameter int INT_W      = 8,
  parameter int FRAC_W     = 12,
  parameter int DEPTH_W    = 8,
  parameter int RATE_W     = 10,
  parameter int STEP_SHIFT = 2
) (
  input  logic               refClk,
  input  logic               rstN,
  input  logic [INT_W-1:0]   nomInt,
  input  logic [FRAC_W-1:0]  nomFrac,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [RATE_W-1:0]  rateDiv,
  input  logic               downEn,
  input  logic               spreadEn,
  output logic [INT_W-1:0]   modInt,
  output logic [FRAC_W-1:0]  modFrac,
  output logic [1:0]         phase
);

  strobe_t            stb;
  logic [DEPTH_W-1:0] depthQ;
  logic               downQ;
  logic [1:0]         quarter;

  ssfb_ctrl #(
    .DEPTH_W   (DEPTH_W),
    .RATE_W    (RATE_W),
    .STEP_SHIFT(STEP_SHIFT)
  ) u_ctrl (
    .refClk  (refClk),
    .rstN    (rstN),
    .spreadEn(spreadEn),
    .downEn  (downEn),
    .depth   (depth),
    .rateDiv (rateDiv),
    .stb     (stb),
    .depthQ  (depthQ),
    .downQ   (downQ),
    .quarter (quarter)
  );

  ssfb_datapath #(
    .INT_W     (INT_W),
    .FRAC_W    (FRAC_W),
    .DEPTH_W   (DEPTH_W),
    .STEP_SHIFT(STEP_SHIFT)
  ) u_dp (
    .refClk   (refClk),
    .rstN     (rstN),
    .stb      (stb),
    .depthQ   (depthQ),
    .downQ    (downQ),
    .quarterIn(quarter),
    .nomInt   (nomInt),
    .nomFrac  (nomFrac),
    .modInt   (modInt),
    .modFrac  (modFrac),
    .phase    (phase)
  );

endmodule

// File: tb/tb_ssfb_modulator.sv
module tb_ssfb_modulator;

  localparam int CLK_PERIOD = 10;
  localparam int STEPS      = 4;
  localparam int MIN_RATE   = 18;
  localparam int MODULUS    = 1 << 20;

  logic        refClk   = 1'b0;
  logic        rstN     = 1'b0;
  logic [7:0]  nomInt   = '0;
  logic [11:0] nomFrac  = '0;
  logic [7:0]  depth    = '0;
  logic [9:0]  rateDiv  = 10'd18;
  logic        downEn   = 1'b0;
  logic        spreadEn = 1'b0;
  logic [7:0]  modInt;
  logic [11:0] modFrac;
  logic [1:0]  phase;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 1'b0;

  ssfb_modulator dut (
    .refClk  (refClk),
    .rstN    (rstN),
    .nomInt  (nomInt),
    .nomFrac (nomFrac),
    .depth   (depth),
    .rateDiv (rateDiv),
    .downEn  (downEn),
    .spreadEn(spreadEn),
    .modInt  (modInt),
    .modFrac (modFrac),
    .phase   (phase)
  );

  always #(CLK_PERIOD/2) refClk = ~refClk;

  function automatic int lvlOf(int n, int d);
    int p = n % (4 * STEPS);
    int q = p / STEPS;
    int k = p % STEPS;
    case (q)
      0:       return k * d;
      1:       return (STEPS - k) * d;
      2:       return -k * d;
      default: return -(STEPS - k) * d;
    endcase
  endfunction

  function automatic int offOf(int n, int d, bit dn);
    int lv  = lvlOf(n, d);
    int mag = (lv < 0 ? -lv : lv) / STEPS;
    int c   = (lv < 0) ? -mag : mag;
    return dn ? (c - d) : c;
  endfunction

  function automatic int stepsAt(int edges, int dv);
    return ((edges / 4) * (4 * STEPS)) / dv;
  endfunction

  task automatic expectOut(string req, int expVal, int expPhase);
    int m = expVal % MODULUS;
    logic [19:0] act;
    if (m < 0) m += MODULUS;
    act = {modInt, modFrac};
    compared++;
    if (act != m[19:0] || phase != expPhase[1:0]) begin
      mismatched++;
      $display("FAIL %s (phase per R7): value 0x%05h phase %0d, expected 0x%05h phase %0d",
               req, act, phase, m[19:0], expPhase);
    end
  endtask

  task automatic runProfile(string req, int ni, int nf, int d, int dv, bit dn);
    int effDiv = (dv < MIN_RATE) ? MIN_RATE : dv;
    int nomVal = ni * 4096 + nf;
    int cycles = 4 * effDiv + 8;
    @(negedge refClk);
    spreadEn = 1'b0;
    nomInt = ni[7:0]; nomFrac = nf[11:0]; depth = d[7:0];
    rateDiv = dv[9:0]; downEn = dn;
    @(negedge refClk);
    @(negedge refClk);
    expectOut("R9 idle", nomVal, 0);
    spreadEn = 1'b1;
    for (int e = 1; e <= cycles; e++) begin
      int n;
      @(negedge refClk);
      n = stepsAt(e - 1, effDiv);
      expectOut(req, nomVal + offOf(n, d, dn), (n % 16) / 4);
    end
  endtask

  initial begin
    int depths[6] = '{0, 1, 3, 7, 100, 255};
    int rates[4]  = '{18, 19, 25, 33};
    int nomVal;

    // R1: reset state, and R10 nominal passes through without an edge
    nomInt = 8'h35; nomFrac = 12'h7A0;
    @(negedge refClk);
    expectOut("R1 reset", 32'h35 * 4096 + 32'h7A0, 0);
    nomFrac = 12'h123;
    #1;
    expectOut("R10 nominal during reset", 32'h35 * 4096 + 32'h123, 0);
    @(negedge refClk);
    rstN = 1'b1;

    // R2/R3/R4: sweep depth, rate and mode
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 4; j++) begin
        runProfile("R2/R4 centre", 8'h40, 12'h800, depths[i], rates[j], 1'b0);
        runProfile("R3/R4 down",   8'h40, 12'h800, depths[i], rates[j], 1'b1);
      end
    end

    // R5: illegal rate values behave as 18
    runProfile("R5 clamp 5",  8'h22, 12'h400, 50, 5, 1'b0);
    runProfile("R5 clamp 0",  8'h22, 12'h400, 50, 0, 1'b1);

    // R6: carry and borrow across the fraction/integer boundary, and wrap
    runProfile("R6 carry",       7,   12'hFF0, 200, 18, 1'b0);
    runProfile("R6 borrow",      9,   12'h010, 200, 18, 1'b1);
    runProfile("R6 wrap low",    0,   0,       255, 19, 1'b1);
    runProfile("R6 wrap high",   255, 12'hFFF, 255, 18, 1'b0);

    // R8: depth and mode change inside quarter 0 take effect at the midpoint
    @(negedge refClk);
    spreadEn = 1'b0; nomInt = 8'h30; nomFrac = 12'h200;
    depth = 8'd40; rateDiv = 10'd20; downEn = 1'b0;
    @(negedge refClk);
    @(negedge refClk);
    spreadEn = 1'b1;
    nomVal = 32'h30 * 4096 + 32'h200;
    for (int e = 1; e <= 80; e++) begin
      int n;
      int dEff;
      bit dnEff;
      @(negedge refClk);
      n = stepsAt(e - 1, 20);
      dEff  = (n < 8) ? 40 : 100;
      dnEff = (n >= 8);
      expectOut("R8 midpoint update", nomVal + offOf(n, dEff, dnEff), (n % 16) / 4);
      if (e == 9) begin
        depth = 8'd100; downEn = 1'b1;
      end
    end

    // R10 while running, then R9 disable and restart
    @(negedge refClk);
    spreadEn = 1'b0; nomInt = 8'h20; nomFrac = 12'h400;
    depth = 8'd80; rateDiv = 10'd18; downEn = 1'b0;
    @(negedge refClk);
    @(negedge refClk);
    spreadEn = 1'b1;
    nomVal = 32'h20 * 4096 + 32'h400;
    for (int e = 1; e <= 30; e++) begin
      int n;
      @(negedge refClk);
      n = stepsAt(e - 1, 18);
      expectOut("R4 pre-disable", nomVal + offOf(n, 80, 1'b0), (n % 16) / 4);
    end
    nomFrac = 12'h555;
    nomVal = 32'h20 * 4096 + 32'h555;
    #1;
    expectOut("R10 nominal while running", nomVal + offOf(stepsAt(29, 18), 80, 1'b0),
              (stepsAt(29, 18) % 16) / 4);
    @(negedge refClk);
    spreadEn = 1'b0;
    @(negedge refClk);
    expectOut("R9 disable", nomVal, 0);
    spreadEn = 1'b1;
    for (int e = 1; e <= 12; e++) begin
      int n;
      @(negedge refClk);
      n = stepsAt(e - 1, 18);
      expectOut("R9 restart", nomVal + offOf(n, 80, 1'b0), (n % 16) / 4);
    end

    // R1: asynchronous reset in the middle of a sweep
    repeat (5) @(negedge refClk);
    rstN = 1'b0;
    #1;
    expectOut("R1 reset mid-sweep", nomVal, 0);
    spreadEn = 1'b0;
    @(negedge refClk);
    rstN = 1'b1;
    @(negedge refClk);
    expectOut("R1 after reset", nomVal, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge refClk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete (all requirements), got hang, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule